// File: doc/BRIEF.md
# Input Change Notification Interrupt

The block watches a bank of input signals and raises an interrupt request when any input that software has selected changes level, whether it rises or falls. Each input passes through a two-stage synchronizer. It is then compared with a stored reference word holding the last accepted input values. Any enabled bit that differs sets a sticky flag, which stays set until software clears it. Each input also has its own pull-up enable bit, and these bits are driven out toward the pads.

Software uses a four-word register port. Word 0 holds the input enables and word 1 holds the pull-up enables. Word 2 returns the synchronized input values. Word 3 returns the flag and clears it when written with bit 0 set. When the `sleep` input is high, the clocked logic is treated as stopped and keeps all of its state. In that mode the request is also driven combinationally from any mismatch between the raw inputs and the reference, so a change is reported without a running clock.

Top module: `chg_notify`

## Requirements
- R1: After reset, the enable word, the pull-up word, the flag, the reference and the synchronizer stages are all 0. `irq` and `pull_en` are 0, and `rdata` is 0 at every address.
- R2: A write with `addr`=0 loads the enable word, and a write with `addr`=1 loads the pull-up word. Both are read back at the same address. `pull_en` equals the pull-up word.
- R3: With `sleep`=0, a rising or falling change on an enabled input sets the flag. `irq` is high after the third rising clock edge that follows the change.
- R4: A change on an input whose enable bit is 0 never sets the flag.
- R5: The flag stays set until a write with `addr`=3 and `wdata[0]`=1. A write to `addr`=3 with `wdata[0]`=0 has no effect. If an enabled mismatch is present in the same cycle as a clear, the flag stays set.
- R6: The reference handles updates in three cases:
  - While the flag is clear, the reference takes the synchronized input on every clock.
  - While the flag is set, the reference holds its value. Changes that arrive while the flag is set therefore set the flag again after a clear.
  - `rd_en` with `addr`=2 loads the reference from the synchronized input, whatever the flag.
- R7: While `sleep`=1, no clocked state changes, including register writes, synchronizer stages and the flag. `irq` equals the flag OR any enabled bit where `pin_in` differs from the reference, with no clock delay.
- R8: `rdata` is combinational from `addr`. Address 2 returns the synchronized input word. Address 3 returns the flag in bit 0, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Clocks-stopped mode: freezes state and enables the combinational request |
| pin_in | input | N_IN | Monitored input levels |
| addr | input | 2 | Register word select |
| wr_en | input | 1 | Write strobe for the selected word |
| rd_en | input | 1 | Read strobe; at address 2 it resynchronizes the reference |
| wdata | input | N_IN | Write data |
| rdata | output | N_IN | Read data for the selected word |
| pull_en | output | N_IN | Pull-up enables toward the pads |
| irq | output | 1 | Interrupt request |

## Verification
Register writes show at `rdata` and `pull_en` one edge after the strobe. A change on an input reaches the flag on the third edge after it. While `sleep` is high, the request follows `pin_in` within the same cycle. The bench drives its inputs just after each rising edge. A behavioural model, updated on that same edge, predicts every output. The bench compares the model with the outputs on each falling edge, so each result is checked in the cycle in which it is due. The scenarios include a clear that coincides with a pending mismatch, changes that arrive while the flag is set, and changes that occur during sleep and are then picked up on wake.

// File: rtl/chg_notify.sv
module chg_notify #(
  parameter int N_IN = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep,
  input  logic [N_IN-1:0] pin_in,
  input  logic [1:0]      addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [N_IN-1:0] wdata,
  output logic [N_IN-1:0] rdata,
  output logic [N_IN-1:0] pull_en,
  output logic            irq
);

  logic [N_IN-1:0] sync1, sync2, ref_q, en_q, pu_q;
  logic            flag;

  wire run      = ~sleep;
  wire clr_hit  = wr_en && addr == 2'd3 && wdata[0];
  wire resync   = rd_en && addr == 2'd2;
  wire hit_clk  = |((sync2 ^ ref_q) & en_q);
  wire hit_raw  = |((pin_in ^ ref_q) & en_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else if (run) begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= '0;
      pu_q <= '0;
    end else if (run && wr_en) begin
      if (addr == 2'd0) en_q <= wdata;
      if (addr == 2'd1) pu_q <= wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   ref_q <= '0;
    else if (run && (!flag || resync)) ref_q <= sync2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          flag <= 1'b0;
    else if (run) begin
      if (hit_clk)       flag <= 1'b1;
      else if (clr_hit)  flag <= 1'b0;
    end

  always_comb
    case (addr)
      2'd0:    rdata = en_q;
      2'd1:    rdata = pu_q;
      2'd2:    rdata = sync2;
      default: rdata = {{(N_IN-1){1'b0}}, flag};
    endcase

  assign pull_en = pu_q;
  assign irq     = flag | (sleep & hit_raw);

  p_quiet_awake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !flag) |-> !irq);

  p_pull_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && addr == 2'd1) |=> pull_en == $past(wdata));

  p_masked_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !flag && ((sync2 ^ ref_q) & en_q) == '0) |=> !flag);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(run && clr_hit)) |=> flag);

  p_ref_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && flag && !resync) |=> $stable(ref_q));

  p_sleep_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(flag) && $stable(ref_q) && $stable(en_q) && $stable(sync2)));

endmodule

// File: tb/chg_notify_tb.sv
module chg_notify_tb;
  localparam int N = 24;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0, sleep = 0, wr_en = 0, rd_en = 0;
  logic [N-1:0] pin_in = '0, wdata = '0;
  logic [1:0]   addr = 2'd3;
  logic [N-1:0] rdata, pull_en;
  logic         irq;

  chg_notify #(.N_IN(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .pin_in(pin_in), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .pull_en(pull_en), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  logic [N-1:0] m_en, m_pu, m_ref, m_a, m_b;
  logic         m_flag, mism, nflag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_pu = '0; m_ref = '0; m_a = '0; m_b = '0; m_flag = 0;
    end else if (!sleep) begin
      mism  = |((m_b ^ m_ref) & m_en);
      nflag = m_flag;
      if (mism) nflag = 1;
      else if (wr_en && addr == 2'd3 && wdata[0]) nflag = 0;
      if (!m_flag || (rd_en && addr == 2'd2)) m_ref = m_b;
      if (wr_en && addr == 2'd0) m_en = wdata;
      if (wr_en && addr == 2'd1) m_pu = wdata;
      m_flag = nflag;
      m_b = m_a;
      m_a = pin_in;
    end
  end

  task automatic cmp(string t, string what, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [N-1:0] exp_rd;
    logic         exp_irq;
    if (rst_n && !done) begin
      exp_irq = m_flag | (sleep & |((pin_in ^ m_ref) & m_en));
      case (addr)
        2'd0: exp_rd = m_en;
        2'd1: exp_rd = m_pu;
        2'd2: exp_rd = m_b;
        default: exp_rd = {{(N-1){1'b0}}, m_flag};
      endcase
      cmp(tag, "irq", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, exp_irq});
      cmp(tag, "pull_en", pull_en, m_pu);
      cmp(tag, "rdata", rdata, exp_rd);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    addr = a; wdata = d; wr_en = 1;
    cyc(1);
    wr_en = 0; addr = 2'd3;
  endtask

  task automatic rd_ref();
    addr = 2'd2; rd_en = 1;
    cyc(1);
    rd_en = 0; addr = 2'd3;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD + 3);
    cmp("R1", "irq in reset", {{(N-1){1'b0}}, irq}, '0);
    cmp("R1", "pull_en in reset", pull_en, '0);
    cyc(2);
    rst_n = 1;
    cyc(1);
    tag = "R1";
    for (int a = 0; a < 4; a++) begin addr = a[1:0]; cyc(1); end
    addr = 2'd3;

    tag = "R2";
    wr(2'd0, 24'h0000FF);
    wr(2'd1, 24'hA5A5A5);
    addr = 2'd0; cyc(1); addr = 2'd1; cyc(1); addr = 2'd3;

    tag = "R3";
    pin_in[3] = 1; cyc(6);
    wr(2'd3, 24'h1); cyc(2);
    pin_in[3] = 0; cyc(6);
    wr(2'd3, 24'h1); cyc(2);

    tag = "R4";
    pin_in[20] = 1; cyc(6);
    pin_in[20] = 0; cyc(6);

    tag = "R5";
    pin_in[0] = 1; cyc(5);
    wr(2'd3, 24'h0); cyc(2);
    wr(2'd3, 24'h1); cyc(2);

    tag = "R6";
    pin_in[1] = 1; cyc(5);
    pin_in[1] = 0; cyc(5);
    wr(2'd3, 24'h1); cyc(3);
    addr = 2'd2; cyc(1);
    rd_ref();
    wr(2'd3, 24'h1); cyc(4);

    tag = "R7";
    sleep = 1; cyc(1);
    pin_in[2] = 1; cyc(2);
    pin_in[2] = 0; cyc(2);
    wr(2'd0, 24'hFFFFFF);
    pin_in[2] = 1; cyc(2);
    sleep = 0; cyc(6);
    wr(2'd3, 24'h1); cyc(2);

    tag = "R8";
    addr = 2'd2; pin_in = 24'h5A0F3C; cyc(4);
    addr = 2'd3; cyc(3);
    wr(2'd3, 24'h1); cyc(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule